// File: doc/BRIEF.md
# Satellite Control Tone Encoder

This block turns a short control message for outdoor satellite equipment into a gate signal that switches a 22 kHz carrier on and off. Every bit takes a fixed 1.5 ms slot, and the share of that slot during which the tone is on gives the bit value. A parity bit follows each byte. The message is framed by silent gaps. An optional single-tone or coded short burst can be appended after the message. The carrier is generated somewhere else; this block only decides when the carrier is present.

To send, the user presents up to `MAX_BYTES` bytes on a flat data bus (byte 0 in the lowest eight bits), a length and a burst selector, and pulses `start` for one cycle. `busy` stays high until the final silent interval has ended. `done` then pulses for one cycle. When no transmission is running, the gate copies a static tone enable, so the same pin also serves for continuous tone. All durations are set in microseconds. A divider derived from the clock frequency produces a one-microsecond tick, and starting a command resets that divider.

Top module: `sec_tone_encoder`

## Requirements
- R1: A bit of value 1 drives `tone_gate` high for SHORT_US (500 µs) and then low for LONG_US (1000 µs).
- R2: A bit of value 0 drives `tone_gate` high for LONG_US (1000 µs) and then low for SHORT_US (500 µs).
- R3: Each byte is sent most significant bit first, and message bytes go out in order from byte 0 (`msg_data[7:0]`) up to byte `msg_len`-1.
- R4: After the eight data bits of every byte, one parity bit is sent whose value makes the number of ones across all nine bits odd.
- R5: The output is silent for GAP_US (16 ms) before the first message bit, and silent for another GAP_US after the last message bit.
- R6: With `burst_sel` = 1, the trailing gap is followed by continuous tone for MINI_A_US (12.5 ms) and then TAIL_US (20 ms) of silence.
- R7: With `burst_sel` = 2, the trailing gap is followed by the byte 0xFF in normal bit coding with its parity bit, and then TAIL_US of silence. The values 0 and 3 request no burst, and the command ends right after the trailing gap.
- R8: When `msg_len` = 0, only the two gaps and the requested burst are sent.
- R9: While `busy` is high, a `start` pulse has no effect on the running command. `busy` falls only when the final silence ends, and `done` is high for exactly that one cycle.
- R10: While no command is running, `tone_gate` equals `tone_static`. A command ignores `tone_static` throughout, and afterwards the gate returns to the `tone_static` level.
- R11: Each interval lasts its microsecond count times CLK_HZ/1 000 000 clock cycles, measured exactly from the cycle after `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to send the presented command |
| msg_len | input | $clog2(MAX_BYTES+1) | Number of message bytes; values above MAX_BYTES are clamped |
| msg_data | input | 8*MAX_BYTES | Message bytes, byte 0 in bits [7:0] |
| burst_sel | input | 2 | 0 none, 1 continuous burst, 2 coded 0xFF burst, 3 none |
| tone_static | input | 1 | Tone level while idle |
| tone_gate | output | 1 | High while the carrier should be present |
| busy | output | 1 | High from accepted start until the final silence ends |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The bench builds the block with CLK_HZ = 2 MHz, so the divider issues a tick every second cycle. This shows that each interval covers whole divider periods, and that the divider is reset at start. All microsecond counts are scaled down to short values: 5 and 10 for bit halves, 40 for gaps, 25 for the continuous burst and 50 for the tail. MAX_BYTES is 4. At this scale a full-length message with a coded burst takes a few thousand cycles. Every length and every burst choice, including length zero and the full message, can therefore be measured run by run against an independently built list of high and low intervals.

// File: rtl/sec_tone_encoder.sv
module sec_tone_encoder #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int MAX_BYTES = 8,
  parameter int SHORT_US  = 500,
  parameter int LONG_US   = 1000,
  parameter int GAP_US    = 16000,
  parameter int MINI_A_US = 12500,
  parameter int TAIL_US   = 20000,
  parameter int LW        = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LW-1:0]          msg_len,
  input  logic [8*MAX_BYTES-1:0] msg_data,
  input  logic [1:0]             burst_sel,
  input  logic                   tone_static,
  output logic                   tone_gate,
  output logic                   busy,
  output logic                   done
);

  localparam int DIV   = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int DW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TMAX1 = (GAP_US > TAIL_US) ? GAP_US : TAIL_US;
  localparam int TMAX2 = (MINI_A_US > LONG_US) ? MINI_A_US : LONG_US;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int TW    = $clog2(TMAX + 1);

  localparam logic [TW-1:0] T_SHORT = TW'(SHORT_US - 1);
  localparam logic [TW-1:0] T_LONG  = TW'(LONG_US - 1);
  localparam logic [TW-1:0] T_GAP   = TW'(GAP_US - 1);
  localparam logic [TW-1:0] T_MINIA = TW'(MINI_A_US - 1);
  localparam logic [TW-1:0] T_TAIL  = TW'(TAIL_US - 1);
  localparam logic [DW-1:0] DIV_TOP = DW'(DIV - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_MARK, S_SPACE, S_TRAIL, S_MINIA, S_TAIL
  } state_t;

  state_t                 st;
  logic [DW-1:0]          div_cnt;
  logic [TW-1:0]          tmr;
  logic [8*MAX_BYTES-1:0] buf_q;
  logic [LW-1:0]          len_q, idx;
  logic [1:0]             sel_q;
  logic [7:0]             sr;
  logic [3:0]             bitn;
  logic                   par, in_burst;

  logic          tick, expire, bit_v, next_v;
  logic [LW-1:0] nidx;
  logic [7:0]    next_byte;

  assign tick      = (div_cnt == DIV_TOP);
  assign expire    = tick && (tmr == '0);
  assign bit_v     = (bitn == 4'd8) ? par : sr[7];
  assign next_v    = (bitn == 4'd7) ? (par ^ sr[7]) : sr[6];
  assign nidx      = idx + 1'b1;
  assign next_byte = buf_q[8*nidx +: 8];

  assign busy      = (st != S_IDLE);
  assign tone_gate = (st == S_MARK) || (st == S_MINIA) || ((st == S_IDLE) && tone_static);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div_cnt  <= '0;
      tmr      <= '0;
      buf_q    <= '0;
      len_q    <= '0;
      idx      <= '0;
      sel_q    <= '0;
      sr       <= '0;
      bitn     <= '0;
      par      <= 1'b1;
      in_burst <= 1'b0;
      done     <= 1'b0;
    end else begin
      done    <= 1'b0;
      div_cnt <= tick ? '0 : div_cnt + 1'b1;
      if (tick && tmr != '0) tmr <= tmr - 1'b1;

      unique case (st)
        S_IDLE: if (start) begin
          buf_q    <= msg_data;
          len_q    <= (msg_len > LW'(MAX_BYTES)) ? LW'(MAX_BYTES) : msg_len;
          sel_q    <= burst_sel;
          in_burst <= 1'b0;
          div_cnt  <= '0;
          tmr      <= T_GAP;
          st       <= S_LEAD;
        end

        S_LEAD: if (expire) begin
          if (len_q != '0) begin
            idx  <= '0;
            sr   <= buf_q[7:0];
            bitn <= '0;
            par  <= 1'b1;
            tmr  <= buf_q[7] ? T_SHORT : T_LONG;
            st   <= S_MARK;
          end else begin
            tmr <= T_GAP;
            st  <= S_TRAIL;
          end
        end

        S_MARK: if (expire) begin
          tmr <= bit_v ? T_LONG : T_SHORT;
          st  <= S_SPACE;
        end

        S_SPACE: if (expire) begin
          if (bitn != 4'd8) begin
            par  <= par ^ sr[7];
            sr   <= {sr[6:0], 1'b0};
            bitn <= bitn + 1'b1;
            tmr  <= next_v ? T_SHORT : T_LONG;
            st   <= S_MARK;
          end else if (in_burst) begin
            tmr <= T_TAIL;
            st  <= S_TAIL;
          end else if (nidx < len_q) begin
            idx  <= nidx;
            sr   <= next_byte;
            bitn <= '0;
            par  <= 1'b1;
            tmr  <= next_byte[7] ? T_SHORT : T_LONG;
            st   <= S_MARK;
          end else begin
            tmr <= T_GAP;
            st  <= S_TRAIL;
          end
        end

        S_TRAIL: if (expire) begin
          case (sel_q)
            2'd1: begin
              tmr <= T_MINIA;
              st  <= S_MINIA;
            end
            2'd2: begin
              in_burst <= 1'b1;
              sr       <= 8'hFF;
              bitn     <= '0;
              par      <= 1'b1;
              tmr      <= T_SHORT;
              st       <= S_MARK;
            end
            default: begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          endcase
        end

        S_MINIA: if (expire) begin
          tmr <= T_TAIL;
          st  <= S_TAIL;
        end

        S_TAIL: if (expire) begin
          done <= 1'b1;
          st   <= S_IDLE;
        end

        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module sec_tone_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic tone_gate,
  input logic tone_static,
  input logic tick
);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_start_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> busy);

  p_idle_follows_static_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (tone_gate == tone_static));

  p_edges_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (tone_gate != $past(tone_gate))) |-> $past(tick));

endmodule

bind sec_tone_encoder sec_tone_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .tone_gate(tone_gate), .tone_static(tone_static), .tick(tick)
);

// File: tb/tb_sec_tone_encoder.sv
`timescale 1ns/1ps
module tb_sec_tone_encoder;
  localparam int CLK_HZ = 2_000_000;
  localparam int DIV    = 2;
  localparam int NB     = 4;
  localparam int S      = 5;
  localparam int L      = 10;
  localparam int G      = 40;
  localparam int MA     = 25;
  localparam int TL     = 50;
  localparam int LW     = $clog2(NB + 1);
  localparam int NV     = 8;

  localparam logic [36:0] VEC [NV] = '{
    {3'd1, 2'd0, 32'h0000_00A5},
    {3'd2, 2'd0, 32'h0000_FF00},
    {3'd3, 2'd1, 32'h0080_3412},
    {3'd4, 2'd2, 32'hEFBE_ADDE},
    {3'd0, 2'd1, 32'h0000_0000},
    {3'd0, 2'd2, 32'h0000_0000},
    {3'd1, 2'd3, 32'h0000_0001},
    {3'd0, 2'd0, 32'h0000_0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, tone_static = 1'b0;
  logic [LW-1:0] msg_len = '0;
  logic [8*NB-1:0] msg_data = '0;
  logic [1:0] burst_sel = '0;
  logic tone_gate, busy, done;

  int checks = 0, fails = 0, cyc = 0;
  int exp_lvl [128];
  int exp_len [128];
  int nexp;

  always #5 clk = ~clk;

  sec_tone_encoder #(
    .CLK_HZ(CLK_HZ), .MAX_BYTES(NB), .SHORT_US(S), .LONG_US(L),
    .GAP_US(G), .MINI_A_US(MA), .TAIL_US(TL)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len),
    .msg_data(msg_data), .burst_sel(burst_sel), .tone_static(tone_static),
    .tone_gate(tone_gate), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R9 watchdog: run still active at cycle %0d, expected end before %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  function automatic string tag_of(int i);
    case (i)
      0: return "R1 R2 R3 R4 R5 R11";
      1: return "R2 R1 R3 R4";
      2: return "R3 R6";
      3: return "R7 R9";
      4: return "R8 R6";
      5: return "R8 R7";
      6: return "R7 burst 3";
      default: return "R8 R5";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int lvl, input int ticks);
    if (nexp > 0 && exp_lvl[nexp-1] == lvl) exp_len[nexp-1] += ticks * DIV;
    else begin
      exp_lvl[nexp] = lvl;
      exp_len[nexp] = ticks * DIV;
      nexp++;
    end
  endtask

  task automatic push_byte(input logic [7:0] b);
    int p = 1;
    for (int i = 7; i >= 0; i--) begin
      p ^= int'(b[i]);
      push(1, b[i] ? S : L);
      push(0, b[i] ? L : S);
    end
    push(1, p ? S : L);
    push(0, p ? L : S);
  endtask

  task automatic run_case(input int len, input int bsel, input logic [31:0] data,
                          input bit poke, input string tag);
    int act_len [128];
    int act_lvl [128];
    int nact = 0, cur, cnt = 0, n = 0;
    nexp = 0;
    push(0, G);
    for (int k = 0; k < len; k++) push_byte(data[8*k +: 8]);
    push(0, G);
    if (bsel == 1) begin push(1, MA); push(0, TL); end
    else if (bsel == 2) begin push_byte(8'hFF); push(0, TL); end

    @(negedge clk);
    msg_len = LW'(len); burst_sel = 2'(bsel); msg_data = data; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cur = int'(tone_gate);
    while (busy) begin
      if (int'(tone_gate) != cur) begin
        if (nact < 128) begin act_lvl[nact] = cur; act_len[nact] = cnt; end
        nact++; cur = int'(tone_gate); cnt = 0;
      end
      cnt++; n++;
      if (poke && n == 100) begin
        start = 1'b1; msg_data = ~data; msg_len = '0; burst_sel = 2'd0;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    if (nact < 128) begin act_lvl[nact] = cur; act_len[nact] = cnt; end
    nact++;
    chk(done == 1'b1, {tag, " done at busy fall"}, int'(done), 1);
    chk(nact == nexp, {tag, " run count"}, nact, nexp);
    for (int r = 0; r < nexp && r < nact; r++) begin
      chk(act_lvl[r] == exp_lvl[r], {tag, " run level"}, act_lvl[r], exp_lvl[r]);
      chk(act_len[r] == exp_len[r], {tag, " run length"}, act_len[r], exp_len[r]);
    end
    @(negedge clk);
    chk(done == 1'b0, {tag, " done one cycle R9"}, int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tone_gate == 1'b0, "reset gate", int'(tone_gate), 0);
    chk(busy == 1'b0, "reset busy", int'(busy), 0);
    chk(done == 1'b0, "reset done", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      run_case(int'(VEC[i][36:34]), int'(VEC[i][33:32]), VEC[i][31:0], i == 3, tag_of(i));

    tone_static = 1'b1;
    @(negedge clk);
    chk(tone_gate == 1'b1, "R10 idle static on", int'(tone_gate), 1);
    run_case(1, 1, 32'h0000_0003, 1'b0, "R10 static overridden");
    chk(tone_gate == 1'b1, "R10 static restored", int'(tone_gate), 1);
    tone_static = 1'b0;
    @(negedge clk);
    chk(tone_gate == 1'b0, "R10 idle static off", int'(tone_gate), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule